// File: doc/BRIEF.md
# Instruction Queue Status Tracker

This block sits beside a processor that prefetches code bytes into an internal queue, and keeps a shadow copy of that queue. Every code-fetch read seen on the bus pushes its data byte into the shadow. A 2-bit queue status code from the processor says what the core did with its own queue. The code is either nothing, taking the opening byte of an instruction, taking a later byte of an instruction, or discarding the whole queue.

The status code describes an operation that happened in the previous clock. The tracker therefore applies the code on the edge where it is presented, with no further delay. For each byte the core takes, the tracker registers the shadowed byte and a flag telling whether it opens a new instruction, and raises a valid strobe for one clock. An occupancy count is always visible. Two sticky error flags record a push into a full shadow and a take from an empty one.

Top module: `iqt_tracker`

## Requirements
- R1: With status code 2'b00 and no fetch strobe, the occupancy and the error flags hold, and valid_o stays low on the following cycle.
- R2: A fetch strobe without a pop and without a flush appends fetch_data_i at the tail, and the occupancy rises by one.
- R3: Status code 2'b01 on a non-empty shadow removes the oldest byte. After that edge, valid_o is high for exactly one cycle, with byte_o equal to that byte and first_o high.
- R4: Status code 2'b11 on a non-empty shadow removes the oldest byte the same way as R3, but with first_o low.
- R5: Status code 2'b10 empties the shadow and gives no valid strobe. A fetch strobe on the same edge is stored after the clear, so the occupancy becomes 1 and that byte is the next one removed.
- R6: The shadow holds DEPTH bytes (default 6). A fetch strobe while full, with no pop on that edge, is dropped, the occupancy stays at DEPTH, and overflow_o is set and stays set until reset.
- R7: A pop code (2'b01 or 2'b11) on an empty shadow sets underflow_o, which stays set until reset, and valid_o stays low on the following cycle.
- R8: A pop and a fetch strobe on the same edge leave the occupancy unchanged, even when full, and bytes still leave in arrival order.
- R9: After reset, level_o is 0 and valid_o, first_o, overflow_o and underflow_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_stb_i | input | 1 | Code-fetch read data is present this cycle |
| fetch_data_i | input | 8 | Code byte read by the fetch |
| qstat_i | input | 2 | Queue status code for the previous cycle's operation |
| byte_o | output | 8 | Byte removed from the shadow |
| first_o | output | 1 | Removed byte opens an instruction |
| valid_o | output | 1 | byte_o and first_o are valid this cycle |
| level_o | output | 3 | Bytes currently held in the shadow |
| overflow_o | output | 1 | Sticky: a push found the shadow full |
| underflow_o | output | 1 | Sticky: a pop found the shadow empty |

## Verification
A fetch push and a status-driven removal or flush can land on the same edge. The ordering of the two decides both occupancy and byte order. The bench provokes this on purpose: it pushes and pops at full and at empty, and it pushes during a flush. It also mixes such collisions into a seeded random stream. Each cycle is judged against a reference queue model in the bench, which applies the clear first, then the pop, and then the push.

// File: rtl/iqt_pkg.sv
package iqt_pkg;
  typedef enum logic [1:0] {
    QS_IDLE  = 2'b00,
    QS_FIRST = 2'b01,
    QS_FLUSH = 2'b10,
    QS_NEXT  = 2'b11
  } qstat_e;
endpackage

// File: rtl/iqt_qs_decode.sv
module iqt_qs_decode
  import iqt_pkg::*;
(
  input  logic [1:0] qstat_i,
  output logic       pop_o,
  output logic       first_o,
  output logic       flush_o
);
  qstat_e code;

  always_comb begin
    code    = qstat_e'(qstat_i);
    pop_o   = 1'b0;
    first_o = 1'b0;
    flush_o = 1'b0;
    unique case (code)
      QS_FIRST: begin
        pop_o   = 1'b1;
        first_o = 1'b1;
      end
      QS_NEXT:  pop_o   = 1'b1;
      QS_FLUSH: flush_o = 1'b1;
      default:  ;
    endcase
  end
endmodule

// File: rtl/iqt_ring.sv
module iqt_ring #(
  parameter int DEPTH  = 6,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  input  logic              flush_i,
  output logic              pop_ok_o,
  output logic [DATA_W-1:0] head_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              overflow_o,
  output logic              underflow_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  rd_q, wr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ovf_q, unf_q;
  logic              empty, full, pop_ok, push_ok, push_lost;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == FULL);
  assign pop_ok    = pop_i && !flush_i && !empty;
  // pop frees a slot before the push is placed
  assign push_ok   = push_i && (flush_i || !full || pop_ok);
  assign push_lost = push_i && !push_ok;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[flush_i ? '0 : wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      if (flush_i) begin
        rd_q  <= '0;
        wr_q  <= push_i ? PTR_W'(1) : '0;
        cnt_q <= push_i ? CNT_W'(1) : '0;
      end else begin
        if (push_ok) wr_q <= bump(wr_q);
        if (pop_ok)  rd_q <= bump(rd_q);
        cnt_q <= cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
      end
      if (push_lost) ovf_q <= 1'b1;
      if (pop_i && empty) unf_q <= 1'b1;
    end
  end

  assign pop_ok_o    = pop_ok;
  assign head_o      = mem_q[rd_q];
  assign count_o     = cnt_q;
  assign overflow_o  = ovf_q;
  assign underflow_o = unf_q;

  a_r6_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);
  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !flush_i && full && !pop_i) |=> (cnt_q == FULL) && ovf_q);
  a_r6_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
  a_r7_unf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_q |=> unf_q);
  a_r5_flush_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> cnt_q == CNT_W'($past(push_i)));
  a_r8_level_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !flush_i && !empty) |=> $stable(cnt_q));
  a_r2_push_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !flush_i && !full) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
endmodule

// File: rtl/iqt_out_stage.sv
module iqt_out_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              first_i,
  input  logic [DATA_W-1:0] head_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              first_o,
  output logic              valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o  <= '0;
      first_o <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= take_i;
      first_o <= take_i && first_i;
      if (take_i) byte_o <= head_i;
    end
  end

  a_r3_first_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_o |-> valid_o);
  a_r3_strobe_from_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> valid_o && (byte_o == $past(head_i)));
  a_r4_next_not_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !first_i) |=> !first_o);
endmodule

// File: rtl/iqt_tracker.sv
module iqt_tracker #(
  parameter int DEPTH  = 6,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_stb_i,
  input  logic [DATA_W-1:0] fetch_data_i,
  input  logic [1:0]        qstat_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              first_o,
  output logic              valid_o,
  output logic [CNT_W-1:0]  level_o,
  output logic              overflow_o,
  output logic              underflow_o
);
  logic pop, is_first, flush, pop_ok;
  logic [DATA_W-1:0] head;

  iqt_qs_decode u_dec (
    .qstat_i (qstat_i),
    .pop_o   (pop),
    .first_o (is_first),
    .flush_o (flush)
  );

  iqt_ring #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ring (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (fetch_stb_i),
    .data_i      (fetch_data_i),
    .pop_i       (pop),
    .flush_i     (flush),
    .pop_ok_o    (pop_ok),
    .head_o      (head),
    .count_o     (level_o),
    .overflow_o  (overflow_o),
    .underflow_o (underflow_o)
  );

  iqt_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (pop_ok),
    .first_i (is_first),
    .head_i  (head),
    .byte_o  (byte_o),
    .first_o (first_o),
    .valid_o (valid_o)
  );

  a_r7_no_valid_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qstat_i[0] && level_o == '0) |=> !valid_o && underflow_o);
  a_r5_flush_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qstat_i == 2'b10) |=> !valid_o);
  a_r1_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qstat_i == 2'b00 && !fetch_stb_i) |=> $stable(level_o) && !valid_o);
endmodule

// File: tb/iqt_tracker_test.sv
module iqt_tracker_test;
  localparam int DEPTH = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stb = 1'b0;
  logic [7:0] din = '0;
  logic [1:0] qs = 2'b00;
  logic [7:0] byte_o;
  logic       first_o, valid_o, ovf_o, unf_o;
  logic [2:0] level_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0] mq[$];
  logic       e_valid, e_first, e_ovf, e_unf;
  logic [7:0] e_byte;

  always #5 clk = ~clk;

  iqt_tracker uut (
    .clk_i(clk), .rst_ni(rst_n), .fetch_stb_i(stb), .fetch_data_i(din),
    .qstat_i(qs), .byte_o(byte_o), .first_o(first_o), .valid_o(valid_o),
    .level_o(level_o), .overflow_o(ovf_o), .underflow_o(unf_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference model: clear, then pop, then push
  function automatic void model(input logic s, input logic [7:0] d, input logic [1:0] q);
    e_valid = 1'b0;
    e_first = 1'b0;
    if (q == 2'b10) begin
      mq.delete();
      if (s) mq.push_back(d);
      return;
    end
    if (q[0]) begin
      if (mq.size() == 0) e_unf = 1'b1;
      else begin
        e_byte  = mq.pop_front();
        e_valid = 1'b1;
        e_first = (q == 2'b01);
      end
    end
    if (s) begin
      if (mq.size() < DEPTH) mq.push_back(d);
      else e_ovf = 1'b1;
    end
  endfunction

  task automatic step(input logic s, input logic [7:0] d, input logic [1:0] q);
    string lreq, vreq;
    @(negedge clk);
    stb = s; din = d; qs = q;
    lreq = (q == 2'b10) ? "R5" : (q[0] && s) ? "R8" :
           (s && mq.size() >= DEPTH) ? "R6" : s ? "R2" : q[0] ? "R3" : "R1";
    vreq = (q == 2'b01) ? "R3" : (q == 2'b11) ? "R4" : "R1";
    if (q[0] && mq.size() == 0) vreq = "R7";
    if (q == 2'b10) vreq = "R5";
    model(s, d, q);
    @(posedge clk);
    #2;
    chk(lreq, "level", level_o, mq.size());
    chk(vreq, "valid", valid_o, e_valid);
    if (e_valid) begin
      chk(vreq, "byte", byte_o, e_byte);
      chk(vreq, "first", first_o, e_first);
    end
    chk("R6", "overflow", ovf_o, e_ovf);
    chk("R7", "underflow", unf_o, e_unf);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    e_ovf = 0; e_unf = 0; e_valid = 0; e_first = 0; e_byte = 0;
    repeat (3) @(posedge clk);
    #2;
    // R9 reset state
    chk("R9", "level", level_o, 0);
    chk("R9", "valid", valid_o, 0);
    chk("R9", "first", first_o, 0);
    chk("R9", "overflow", ovf_o, 0);
    chk("R9", "underflow", unf_o, 0);
    @(negedge clk);
    rst_n = 1'b1;

    step(0, 8'h00, 2'b00);                         // R1 idle
    for (int i = 0; i < DEPTH; i++) step(1, 8'h10 + 8'(i), 2'b00); // R2 fill
    step(1, 8'hEE, 2'b11);                         // R8 at full
    step(1, 8'hA0, 2'b01);                         // R8 at full again
    step(0, 8'h00, 2'b01);                         // R3
    step(0, 8'h00, 2'b11);                         // R4
    step(0, 8'h00, 2'b10);                         // R5 flush
    step(0, 8'h00, 2'b01);                         // R7 empty pop
    step(1, 8'h55, 2'b10);                         // R5 flush with push
    step(0, 8'h00, 2'b01);                         // R5 byte 55 next out
    for (int i = 0; i < DEPTH; i++) step(1, 8'h30 + 8'(i), 2'b00);
    step(1, 8'hFF, 2'b00);                         // R6 overflow drop
    step(0, 8'h00, 2'b00);                         // R1 hold while full
    for (int i = 0; i < DEPTH; i++) step(0, 8'h00, (i == 0) ? 2'b01 : 2'b11);

    for (int n = 0; n < 4000; n++) begin
      logic [1:0] q;
      int r = int'($urandom_range(0, 99));
      q = (r < 3) ? 2'b10 : (r < 30) ? 2'b01 : (r < 55) ? 2'b11 : 2'b00;
      step(1'($urandom_range(0, 1)), 8'($urandom), q);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule